// File: doc/BRIEF.md
# Reset Sequencer with Stabilization Counter

This block is the reset and clock-start controller of a small microcontroller. A single 13-bit counter, stepped on the falling edge of the oscillator reference clock, serves three purposes. It stretches every reset through a two-phase release: first the bidirectional open-drain reset pin is let go, then the CPU reset follows a fixed number of cycles later. It keeps the bus clocks gated while the oscillator settles after power-on or a wake from stop mode. Its wrap-around produces the periodic tick that drives an external watchdog.

Reset requests arrive as digital inputs: power-on detect, low-voltage detect, a watchdog timeout, and the level of the external reset pin. The two asynchronous inputs, the pin level and low-voltage detect, pass through a two-flop synchronizer. Each cause sets its own bit in a status register. Software reads that register through a simple read strobe, and a read clears every cause bit except the power-on bit.

Top module: `rstseq_top`

## Requirements
- R1: The stabilization counter is 13 bits wide and advances on every falling edge of `ref_clk`. `wdt_tick` is a pulse one cycle wide that follows each wrap of the counter, so while the block is running the pulses are 8192 falling edges apart.
- R2: A power-on request, a watchdog request, a low-voltage detect, or an external low level on the reset pin each starts a reset sequence, during which `rst_pin_oe` is 1 (1 means the block pulls the pin low).
- R3: In the pin phase, `rst_pin_oe` stays high for exactly 4096 falling edges, counted from the edge that accepted the latest cause.
- R4: `cpu_rst_n` is low for the whole time the pin is driven. It stays low for exactly 64 more falling edges after `rst_pin_oe` falls, and then goes high.
- R5: While the block is running, a low pin level starts a reset and sets the pin flag. The pin level is ignored while the block drives the pin and during the 64-edge CPU-hold phase.
- R6: A new cause that arrives during a sequence restarts the count from zero, so the pin phase lasts 4096 edges after the new cause.
- R7: A power-on request sets the status flags to exactly 4'b0001. It first holds `bus_clk_en` low, the pin driven and the CPU in reset for 4096 edges of oscillator settling, and then runs the 4096-edge pin phase.
- R8: A `stop_wake` pulse while running holds `bus_clk_en` low for 4096 falling edges. During that time it does not drive the pin and does not reset the CPU.
- R9: Status bits are: bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 low-voltage. A cause other than power-on sets its own bit and leaves the other bits unchanged.
- R10: `rd_data` always shows the flags. A falling edge with `rd_en` high clears bits 3:1 and keeps bit 0. A cause that is accepted on the same edge still sets its bit.
- R11: `lvd_in` and `rst_pin_in` each pass through two synchronizer flops. A change applied between edges first drives the pin after the third falling edge.
- R12: While `rst_n` is low the block is in the power-on state: pin driven, CPU in reset, bus clocks off, flags 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Oscillator reference clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low initialisation; acts as a power-on |
| por_req | input | 1 | Power-on detector request, synchronous |
| lvd_in | input | 1 | Low-voltage detector output, asynchronous, high when supply is low |
| wdt_rst | input | 1 | Watchdog timeout request, synchronous |
| rst_pin_in | input | 1 | Sensed level of the reset pad, asynchronous, low means reset |
| stop_wake | input | 1 | Wake-from-stop request pulse, synchronous |
| rd_en | input | 1 | Status read strobe |
| rst_pin_oe | output | 1 | Open-drain pull-down enable for the reset pad |
| cpu_rst_n | output | 1 | Active-low CPU reset |
| bus_clk_en | output | 1 | Bus clock enable |
| wdt_tick | output | 1 | Watchdog prescaler tick |
| rd_data | output | 4 | Reset cause flags |

## Verification
The assertions assume that `por_req`, `wdt_rst` and `stop_wake` are already synchronous to the falling edge of `ref_clk`. They also assume that the pad level seen on `rst_pin_in` reads low whenever the block pulls it low. The bench changes every input only at rising edges, half a period away from the falling edges where the block samples. It models the pad as low whenever either the block or the external source pulls it low. Requests are given as single-cycle pulses, except for the pin, which is held low for three cycles so that it passes through the synchronizer.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: flag bit order is fixed, since software decodes it.
package rstseq_pkg;

    localparam int FLAG_W = 4;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_POR_SETTLE  = 3'd0,
        ST_PIN_HOLD    = 3'd1,
        ST_CPU_HOLD    = 3'd2,
        ST_RUN         = 3'd3,
        ST_WAKE_SETTLE = 3'd4
    } seq_state_t;

    // Reset causes seen in one cycle. Packing order equals the flag bit order.
    typedef struct packed {
        logic lvd;   // bit 3
        logic wdt;   // bit 2
        logic pin;   // bit 1
        logic por;   // bit 0
    } cause_t;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes: each bit is an independent level, so no bus coherency is needed.
module rstseq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw input.
                always_ff @(negedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= async_i;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(negedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rstseq_status.sv
// Reset cause flag register with clear-on-read.
// Assumes: causes arrive synchronised. A power-on overrides all other
// causes, and a set in the same cycle wins over a read clear.
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cause_t            ev,
    input  logic              rd_en,
    output logic [FLAG_W-1:0] flags
);

    localparam logic [FLAG_W-1:0] POR_ONLY = FLAG_W'(1);

    logic [FLAG_W-1:0] kept;
    logic [FLAG_W-1:0] set_bits;

    // Bits that survive this cycle, taking the read clear into account.
    always_comb begin
        kept     = rd_en ? (flags & POR_ONLY) : flags;
        set_bits = {ev.lvd, ev.wdt, ev.pin, 1'b0};
    end

    // Flag register update.
    always_ff @(negedge clk) begin
        if (!rst_n)      flags <= POR_ONLY;
        else if (ev.por) flags <= POR_ONLY;
        else             flags <= kept | set_bits;
    end

endmodule

// File: rtl/rstseq_engine.sv
// Phase sequencer and shared stabilization counter.
// Assumes: PIN_CYCLES + CPU_DELAY and OSC_CYCLES fit in CNT_W bits.
// The counter runs freely in all phases; the pin and CPU phases share one
// run of it, and its wrap produces the watchdog tick.
module rstseq_engine
    import rstseq_pkg::*;
#(
    parameter int CNT_W      = 13,
    parameter int PIN_CYCLES = 4096,
    parameter int CPU_DELAY  = 64,
    parameter int OSC_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_por,
    input  logic       restart_rst,
    input  logic       wake,
    output seq_state_t state,
    output logic       tick
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PIN_LAST = CNT_W'(PIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CPU_LAST = CNT_W'(PIN_CYCLES + CPU_DELAY - 1);
    localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(OSC_CYCLES - 1);

    logic [CNT_W-1:0] cnt, nxt_cnt;
    seq_state_t       nxt_state;

    // Next phase and count: causes first, then the end of each phase.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt + 1'b1;
        if (restart_por) begin
            nxt_state = ST_POR_SETTLE;
            nxt_cnt   = '0;
        end else if (restart_rst) begin
            nxt_state = ST_PIN_HOLD;
            nxt_cnt   = '0;
        end else begin
            case (state)
                ST_POR_SETTLE: if (cnt == OSC_LAST) begin
                    nxt_state = ST_PIN_HOLD;
                    nxt_cnt   = '0;
                end
                ST_PIN_HOLD:    if (cnt == PIN_LAST) nxt_state = ST_CPU_HOLD;
                ST_CPU_HOLD:    if (cnt == CPU_LAST) nxt_state = ST_RUN;
                ST_RUN: if (wake) begin
                    nxt_state = ST_WAKE_SETTLE;
                    nxt_cnt   = '0;
                end
                ST_WAKE_SETTLE: if (cnt == OSC_LAST) nxt_state = ST_RUN;
                default: begin
                    nxt_state = ST_POR_SETTLE;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // Phase and counter registers.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state <= ST_POR_SETTLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Watchdog tick: one pulse per counter wrap.
    always_ff @(negedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= (cnt == CNT_MAX);
    end

endmodule

// File: rtl/rstseq_top.sv
// Reset sequencer top: synchronises pad and detector levels, collects the
// causes, runs the phase engine and decodes the pad, CPU and clock controls.
// Assumes: the pad reads low whenever rst_pin_oe is high.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int CNT_W      = 13,
    parameter int PIN_CYCLES = 4096,
    parameter int CPU_DELAY  = 64,
    parameter int OSC_CYCLES = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              por_req,
    input  logic              lvd_in,
    input  logic              wdt_rst,
    input  logic              rst_pin_in,
    input  logic              stop_wake,
    input  logic              rd_en,
    output logic              rst_pin_oe,
    output logic              cpu_rst_n,
    output logic              bus_clk_en,
    output logic              wdt_tick,
    output logic [FLAG_W-1:0] rd_data
);

    logic [1:0] raw_lvl, sync_lvl;
    logic       lvd_s, pin_low_s;
    logic       pin_watch;
    cause_t     ev;
    seq_state_t state;

    // Asynchronous levels: low-voltage detect and pin-low, both active high.
    assign raw_lvl = {lvd_in, ~rst_pin_in};

    rstseq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .async_i (raw_lvl),
        .sync_o  (sync_lvl)
    );

    assign lvd_s     = sync_lvl[1];
    assign pin_low_s = sync_lvl[0];

    // Pin is only a cause when neither the block nor its release tail owns it.
    assign pin_watch = (state == ST_RUN) || (state == ST_WAKE_SETTLE);

    // Collect this cycle's causes.
    always_comb begin
        ev.por = por_req;
        ev.lvd = lvd_s;
        ev.wdt = wdt_rst;
        ev.pin = pin_low_s & pin_watch;
    end

    rstseq_status u_status (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .ev    (ev),
        .rd_en (rd_en),
        .flags (rd_data)
    );

    rstseq_engine #(
        .CNT_W      (CNT_W),
        .PIN_CYCLES (PIN_CYCLES),
        .CPU_DELAY  (CPU_DELAY),
        .OSC_CYCLES (OSC_CYCLES)
    ) u_engine (
        .clk         (ref_clk),
        .rst_n       (rst_n),
        .restart_por (ev.por),
        .restart_rst (ev.lvd | ev.wdt | ev.pin),
        .wake        (stop_wake),
        .state       (state),
        .tick        (wdt_tick)
    );

    // Output decode from the phase.
    always_comb begin
        rst_pin_oe = (state == ST_POR_SETTLE) || (state == ST_PIN_HOLD);
        cpu_rst_n  = !((state == ST_POR_SETTLE) || (state == ST_PIN_HOLD) ||
                       (state == ST_CPU_HOLD));
        bus_clk_en = !((state == ST_POR_SETTLE) || (state == ST_WAKE_SETTLE));
    end

endmodule

// File: rtl/rstseq_checker.sv
// Temporal properties of the reset sequencer, bound into the top module.
// Assumes: synchronous requests are stable around falling edges.
module rstseq_checker (
    input logic       ref_clk,
    input logic       rst_n,
    input logic       por_req,
    input logic       wdt_rst,
    input logic       rst_pin_oe,
    input logic       cpu_rst_n,
    input logic       bus_clk_en,
    input logic       wdt_tick,
    input logic [3:0] rd_data
);

    p_tick_single_r1: assert property (@(negedge ref_clk) disable iff (!rst_n)
        wdt_tick |=> !wdt_tick);

    p_wdt_starts_r2: assert property (@(negedge ref_clk) disable iff (!rst_n)
        wdt_rst |=> rst_pin_oe);

    p_cpu_held_r4: assert property (@(negedge ref_clk) disable iff (!rst_n)
        rst_pin_oe |-> !cpu_rst_n);

    p_release_order_r4: assert property (@(negedge ref_clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> (!rst_pin_oe && $past(!rst_pin_oe)));

    p_por_flags_r7: assert property (@(negedge ref_clk) disable iff (!rst_n)
        por_req |=> (rd_data == 4'b0001));

    p_wake_quiet_r8: assert property (@(negedge ref_clk) disable iff (!rst_n)
        (!bus_clk_en && cpu_rst_n) |-> !rst_pin_oe);

    p_por_sticky_r10: assert property (@(negedge ref_clk) disable iff (!rst_n)
        (rd_data[0] && !por_req) |=> rd_data[0]);

endmodule

bind rstseq_top rstseq_checker u_chk (.*);

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;

    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_req = 1'b0, lvd_in = 1'b0, wdt_rst = 1'b0;
    logic       stop_wake = 1'b0, rd_en = 1'b0, ext_low = 1'b0;
    logic       rst_pin_in;
    logic       rst_pin_oe, cpu_rst_n, bus_clk_en, wdt_tick;
    logic [3:0] rd_data;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #2 ref_clk = ~ref_clk;   // 250 MHz

    // Open-drain pad: low if the block or the external source pulls it.
    assign rst_pin_in = (rst_pin_oe || ext_low) ? 1'b0 : 1'b1;

    rstseq_top dut (
        .ref_clk(ref_clk), .rst_n(rst_n), .por_req(por_req), .lvd_in(lvd_in),
        .wdt_rst(wdt_rst), .rst_pin_in(rst_pin_in), .stop_wake(stop_wake),
        .rd_en(rd_en), .rst_pin_oe(rst_pin_oe), .cpu_rst_n(cpu_rst_n),
        .bus_clk_en(bus_clk_en), .wdt_tick(wdt_tick), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cnt_oe(output int n);
        n = 0;
        while (rst_pin_oe === 1'b1 && n < 20000) begin n++; @(posedge ref_clk); end
    endtask

    task automatic cnt_cpu_hold(output int n);
        n = 0;
        while (cpu_rst_n === 1'b0 && rst_pin_oe === 1'b0 && n < 20000) begin
            n++; @(posedge ref_clk);
        end
    endtask

    task automatic cnt_bus_off(output int n);
        n = 0;
        while (bus_clk_en === 1'b0 && n < 20000) begin n++; @(posedge ref_clk); end
    endtask

    // Pin phase then CPU-hold phase, from the current sample.
    task automatic check_tail(input string req);
        int n;
        cnt_oe(n);       chk({req, " R3 pin phase"}, n, 4096);
        cnt_cpu_hold(n); chk({req, " R4 cpu tail"}, n, 64);
        chk({req, " R4 cpu released"}, cpu_rst_n, 1);
    endtask

    task automatic t_power_up();
        int n;
        repeat (3) @(posedge ref_clk);
        chk("R12 oe", rst_pin_oe, 1);
        chk("R12 cpu", cpu_rst_n, 0);
        chk("R12 bus", bus_clk_en, 0);
        chk("R12 flags", rd_data, 1);
        rst_n = 1'b1;
        cnt_bus_off(n);  chk("R7 settle", n, 4096);
        check_tail("R7");
    endtask

    task automatic t_tick();
        int n = 0;
        while (!wdt_tick && n < 10000) begin n++; @(posedge ref_clk); end
        @(posedge ref_clk);
        chk("R1 tick width", wdt_tick, 0);
        n = 1;
        while (!wdt_tick && n < 10000) begin n++; @(posedge ref_clk); end
        chk("R1 tick period", n, 8192);
    endtask

    task automatic t_wdt();
        chk("R9 flags before", rd_data, 1);
        @(posedge ref_clk); wdt_rst = 1'b1;
        @(posedge ref_clk); wdt_rst = 1'b0;
        chk("R2 wdt drives pin", rst_pin_oe, 1);
        check_tail("R2");
        chk("R9 wdt flag", rd_data, 4'b0101);
    endtask

    task automatic t_lvd();
        @(posedge ref_clk); lvd_in = 1'b1;
        @(posedge ref_clk); lvd_in = 1'b0;
        chk("R11 lvd edge1", rst_pin_oe, 0);
        @(posedge ref_clk);
        chk("R11 lvd edge2", rst_pin_oe, 0);
        @(posedge ref_clk);
        chk("R11 lvd edge3", rst_pin_oe, 1);
        check_tail("R11");
        chk("R9 lvd flag", rd_data, 4'b1101);
    endtask

    task automatic t_read();
        @(posedge ref_clk); rd_en = 1'b1;
        chk("R10 read value", rd_data, 4'b1101);
        @(posedge ref_clk); rd_en = 1'b0;
        chk("R10 read clears", rd_data, 4'b0001);
        rd_en = 1'b1; wdt_rst = 1'b1;
        @(posedge ref_clk); rd_en = 1'b0; wdt_rst = 1'b0;
        chk("R10 set wins", rd_data, 4'b0101);
        check_tail("R10");
    endtask

    task automatic t_restart();
        int n = 0;
        @(posedge ref_clk); wdt_rst = 1'b1;
        @(posedge ref_clk); wdt_rst = 1'b0;
        while (rst_pin_oe === 1'b1 && n < 20000) begin
            n++;
            if (n == 1000) wdt_rst = 1'b1;
            @(posedge ref_clk);
            wdt_rst = 1'b0;
        end
        chk("R6 restarted pin phase", n, 5096);
        cnt_cpu_hold(n); chk("R6 cpu tail", n, 64);
    endtask

    task automatic t_pin();
        int n;
        @(posedge ref_clk); ext_low = 1'b1;
        @(posedge ref_clk);
        chk("R11 pin edge1", cpu_rst_n, 1);
        @(posedge ref_clk);
        chk("R11 pin edge2", cpu_rst_n, 1);
        @(posedge ref_clk); ext_low = 1'b0;
        chk("R5 pin drives", rst_pin_oe, 1);
        cnt_oe(n);       chk("R5 pin phase", n, 4096);
        cnt_cpu_hold(n); chk("R5 cpu tail ignores pin", n, 64);
        chk("R5 pin flag", rd_data, 4'b0111);
    endtask

    task automatic t_wake();
        int n = 0, bad = 0;
        @(posedge ref_clk); stop_wake = 1'b1;
        @(posedge ref_clk); stop_wake = 1'b0;
        while (bus_clk_en === 1'b0 && n < 20000) begin
            n++;
            if (rst_pin_oe !== 1'b0 || cpu_rst_n !== 1'b1) bad++;
            @(posedge ref_clk);
        end
        chk("R8 wake settle", n, 4096);
        chk("R8 no reset during wake", bad, 0);
    endtask

    task automatic t_por();
        int n;
        @(posedge ref_clk); por_req = 1'b1;
        @(posedge ref_clk); por_req = 1'b0;
        chk("R7 por flags", rd_data, 4'b0001);
        chk("R2 por drives pin", rst_pin_oe, 1);
        cnt_bus_off(n); chk("R7 por settle", n, 4096);
        check_tail("R7 por");
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_power_up();
        t_tick();
        t_wdt();
        t_lvd();
        t_read();
        t_restart();
        t_pin();
        t_wake();
        t_por();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule